// File: doc/BRIEF.md
# Dynamic Bus-Sizing Transfer Sequencer

The sequencer takes a single operand request from a 32-bit core (byte address, operand length of one to four bytes, direction, write data) and breaks it into the bus cycles needed to move it over an external bus whose slaves may be 8, 16 or 32 bits wide. The slave's width is not known in advance. Each acknowledge tells the sequencer the port width, and from that the sequencer works out how many bytes went across. It then moves the address forward by that amount and starts the next cycle, until every byte of the operand has been moved.

Every cycle drives the current byte address and a two-bit code saying how many operand bytes are still outstanding. On writes the next outstanding bytes are placed on the data lanes so that a port of any width finds its bytes where it expects them. On reads the returned bytes are picked from the lanes that match the port width and the address. They are shifted into a result register, most significant byte first. An instruction fetch from an odd address starts no bus cycle and raises an address-error pulse instead. Data operands may have any alignment and only cost extra cycles.

Top module: `bsz_sequencer`

## Requirements
- R1: After a synchronous reset, `bus_cyc`, `busy`, `done` and `addr_err` are all 0.
- R2: During every bus cycle, `bus_siz` gives the number of operand bytes still outstanding. The codes are 2'b01 for one, 2'b10 for two, 2'b11 for three and 2'b00 for four. `req_size` uses the same encoding.
- R3: An acknowledge of 2'b11 (32-bit port) moves min(outstanding, 4 − address[1:0]) bytes.
- R4: An acknowledge of 2'b10 (16-bit port, upper lanes D31–D16) moves min(outstanding, 2 − address[0]) bytes.
- R5: An acknowledge of 2'b01 (8-bit port, lane D31–D24) moves exactly one byte.
- R6: The first cycle presents the request address. Each acknowledged cycle that is not the last is followed, in the next clock, by a cycle whose address has advanced by the bytes moved, modulo 2^ADDR_W.
- R7: On writes, the operand's most significant outstanding byte goes first. For a port of offset o (o = address[1:0] for 32-bit, address[0] for 16-bit, 0 for 8-bit), outstanding byte k appears on lane 3 − o − k, where lane 3 is D31–D24.
- R8: After the last acknowledge, `done` pulses high for one clock and `bus_cyc` drops. For reads, `rdata` then holds the operand, with the bytes that came first in the more significant positions and right-justified to the operand length.
- R9: An instruction-fetch request (`req_fetch` = 1) at an odd address starts no bus cycle and pulses `addr_err` for one clock.
- R10: Data requests at any alignment, and fetches at even addresses, never raise `addr_err`.
- R11: An acknowledge of 2'b00 is a wait state. Address, size code and lane data stay unchanged, and the cycle continues.
- R12: `req_start` is ignored while `busy` is high.
- R13: A four-byte write at address offset 1 to a 16-bit port takes three cycles: low address bits 001 with code 00, then 010 with code 11, then 100 with code 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start an operand transfer (taken only when idle) |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 2 | Operand length, encoded as in R2 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_wdata | input | 32 | Write operand, right-justified |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| addr_err | output | 1 | One-clock address-error pulse |
| rdata | output | 32 | Assembled read operand |
| bus_cyc | output | 1 | Bus cycle active |
| bus_addr | output | ADDR_W | Current byte address |
| bus_siz | output | 2 | Outstanding-bytes code |
| bus_read | output | 1 | 1 = read cycle |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ack | input | 2 | Acknowledge: 11 = 32-bit, 10 = 16-bit, 01 = 8-bit, 00 = wait |

## Verification
The bench builds the block with ADDR_W = 16. This puts the top of the address space within reach, so operands that straddle 0xFFFF and wrap to 0x0000 are covered alongside ordinary misaligned ones. The slave model picks an 8-, 16- or 32-bit port width per operand and inserts random wait states. This covers every alignment, every operand length from one to four bytes, and both directions against each port width. Ignored requests are injected during wait states.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef enum logic [1:0] {
    PORT_WAIT = 2'b00,
    PORT_8    = 2'b01,
    PORT_16   = 2'b10,
    PORT_32   = 2'b11
  } port_e;

  // outstanding-bytes code to a byte count (00 stands for four)
  function automatic logic [2:0] code_to_bytes(input logic [1:0] c);
    return (c == 2'b00) ? 3'd4 : {1'b0, c};
  endfunction
endpackage

// File: rtl/bsz_advance.sv
module bsz_advance (
  input  logic [1:0] off,
  input  logic [2:0] rem,
  input  logic [1:0] ack,
  output logic [2:0] nbytes
);
  import bsz_pkg::*;
  logic [2:0] room;

  always_comb begin
    unique case (port_e'(ack))
      PORT_32: room = 3'd4 - {1'b0, off};
      PORT_16: room = 3'd2 - {2'b00, off[0]};
      PORT_8:  room = 3'd1;
      default: room = 3'd0;
    endcase
    nbytes = (rem < room) ? rem : room;
  end
endmodule

// File: rtl/bsz_wr_steer.sv
module bsz_wr_steer (
  input  logic [31:0] wbuf,
  input  logic [1:0]  off,
  output logic [31:0] dout
);
  for (genvar L = 0; L < 4; L++) begin : g_lane
    logic [1:0] idx;
    always_comb begin
      if (L == 3)      idx = 2'd0;
      else if (L == 2) idx = off[0] ? 2'd0 : 2'd1;
      else             idx = (off <= 2'(3 - L)) ? (2'(3 - L) - off) : 2'd0;
    end
    assign dout[8*L +: 8] = wbuf[{~idx, 3'b000} +: 8];
  end
endmodule

// File: rtl/bsz_rd_pack.sv
module bsz_rd_pack (
  input  logic [31:0] din,
  input  logic [1:0]  off,
  input  logic [2:0]  nbytes,
  input  logic [31:0] acc,
  output logic [31:0] packed_o
);
  logic [31:0] grab;

  always_comb begin
    grab = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(nbytes) && (3 - int'(off) - k) >= 0)
        grab = {grab[23:0], din[8*(3 - int'(off) - k) +: 8]};
    end
    packed_o = (acc << {nbytes, 3'b000}) | grab;
  end
endmodule

// File: rtl/bsz_sequencer.sv
module bsz_sequencer #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic              addr_err,
  output logic [31:0]       rdata,
  output logic              bus_cyc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_read,
  output logic [31:0]       bus_dout,
  input  logic [31:0]       bus_din,
  input  logic [1:0]        bus_ack
);
  import bsz_pkg::*;

  logic              cyc_q, wr_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q, step, req_bytes;
  logic [31:0]       wbuf_q, rbuf_q, rdata_q, packed_w;
  logic [1:0]        eff_off;
  logic              start_ok, odd_fetch, last;

  always_comb begin
    unique case (port_e'(bus_ack))
      PORT_32: eff_off = addr_q[1:0];
      PORT_16: eff_off = {1'b0, addr_q[0]};
      default: eff_off = 2'b00;
    endcase
  end

  bsz_advance i_adv (
    .off(addr_q[1:0]), .rem(rem_q), .ack(bus_ack), .nbytes(step)
  );

  bsz_wr_steer i_steer (
    .wbuf(wbuf_q), .off(addr_q[1:0]), .dout(bus_dout)
  );

  bsz_rd_pack i_pack (
    .din(bus_din), .off(eff_off), .nbytes(step), .acc(rbuf_q), .packed_o(packed_w)
  );

  assign req_bytes = code_to_bytes(req_size);
  assign start_ok  = req_start && !cyc_q;
  assign odd_fetch = req_fetch && req_addr[0];
  assign last      = (rem_q == step);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q   <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      rem_q   <= 3'd0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_ok) begin
        if (odd_fetch) begin
          err_q <= 1'b1;
        end else begin
          cyc_q  <= 1'b1;
          wr_q   <= req_write;
          addr_q <= req_addr;
          rem_q  <= req_bytes;
          wbuf_q <= req_wdata << {3'd4 - req_bytes, 3'b000};
          rbuf_q <= '0;
        end
      end else if (cyc_q && bus_ack != 2'b00) begin
        addr_q <= addr_q + ADDR_W'(step);
        rem_q  <= rem_q - step;
        wbuf_q <= wbuf_q << {step, 3'b000};
        rbuf_q <= packed_w;
        if (last) begin
          cyc_q  <= 1'b0;
          done_q <= 1'b1;
          if (!wr_q) rdata_q <= packed_w;
        end
      end
    end
  end

  assign busy     = cyc_q;
  assign done     = done_q;
  assign addr_err = err_q;
  assign rdata    = rdata_q;
  assign bus_cyc  = cyc_q;
  assign bus_addr = addr_q;
  assign bus_siz  = rem_q[1:0];
  assign bus_read = !wr_q;
endmodule

// File: rtl/bsz_sequencer_chk.sv
module bsz_sequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              addr_err,
  input logic              bus_cyc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_siz,
  input logic [31:0]       bus_dout,
  input logic [1:0]        bus_ack
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!bus_cyc && !busy && !done && !addr_err));

  // R11
  a_r11_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_ack == 2'b00) |=>
      (bus_cyc && $stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout)));

  // R9
  a_r9_err_no_cycle: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (!bus_cyc && !done));

  // R8
  a_r8_done_ends_cycle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_cyc && !busy));

  // R5
  a_r5_byte_port_step: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_ack == 2'b01 && bus_siz != 2'b01) |=>
      (bus_cyc && bus_addr == $past(bus_addr) + ADDR_W'(1)));

  // R2
  a_r2_size_steps_down: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_ack != 2'b00 && bus_siz == 2'b01) |=> (!bus_cyc && done));
endmodule

bind bsz_sequencer bsz_sequencer_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .addr_err(addr_err),
  .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_siz(bus_siz),
  .bus_dout(bus_dout), .bus_ack(bus_ack)
);

// File: tb/test_bsz_sequencer.sv
module test_bsz_sequencer;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_start = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'b00;
  logic [31:0]   req_wdata = '0;
  logic          busy, done, addr_err, bus_cyc, bus_read;
  logic [31:0]   rdata, bus_dout;
  logic [31:0]   bus_din = '0;
  logic [1:0]    bus_ack = 2'b00, bus_siz;
  logic [AW-1:0] bus_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] opb [4];

  always #10 clk = ~clk;

  bsz_sequencer #(.ADDR_W(AW)) i_bsz_sequencer (
    .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_fetch(req_fetch),
    .req_wdata(req_wdata), .busy(busy), .done(done), .addr_err(addr_err),
    .rdata(rdata), .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_siz(bus_siz),
    .bus_read(bus_read), .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ack_of(input int port);
    return (port == 32) ? 2'b11 : (port == 16) ? 2'b10 : 2'b01;
  endfunction

  function automatic int offset_of(input int port, input logic [AW-1:0] a);
    return (port == 32) ? int'(a[1:0]) : (port == 16) ? int'(a[0]) : 0;
  endfunction

  task automatic run_op(input logic [AW-1:0] a, input int sz, input bit wr,
                        input bit fetch, input int port, input int maxwait, input bit poke);
    logic [31:0] wv, expr, fill;
    logic [AW-1:0] cur;
    int cons, rem, off, room, n, w;
    string ptag;
    wv = '0;
    for (int i = 0; i < sz; i++) begin
      opb[i] = 8'($urandom);
      wv = {wv[23:0], opb[i]};
    end
    ptag = (port == 32) ? "R3" : (port == 16) ? "R4" : "R5";
    @(negedge clk);
    req_start = 1'b1; req_addr = a; req_size = 2'(sz); req_write = wr;
    req_fetch = fetch; req_wdata = wv;
    @(negedge clk);
    req_start = 1'b0;
    if (fetch && a[0]) begin
      chk(addr_err == 1'b1, "R9 addr_err", 32'(addr_err), 32'd1);
      chk(bus_cyc == 1'b0, "R9 no cycle", 32'(bus_cyc), 32'd0);
      @(negedge clk);
      chk(!bus_cyc && !busy && !addr_err, "R9 stays idle", {busy, bus_cyc, addr_err}, 32'd0);
      return;
    end
    chk(addr_err == 1'b0, "R10 no fault", 32'(addr_err), 32'd0);
    cons = 0; cur = a;
    while (cons < sz) begin
      rem  = sz - cons;
      off  = offset_of(port, cur);
      room = ((port == 32) ? 4 : (port == 16) ? 2 : 1) - off;
      n    = (rem < room) ? rem : room;
      chk(bus_cyc == 1'b1, "R6 cycle active", 32'(bus_cyc), 32'd1);
      chk(bus_addr == cur, (cons == 0) ? "R6 start addr" : {ptag, " advance"}, 32'(bus_addr), 32'(cur));
      chk(bus_siz == 2'(rem), "R2 size code", 32'(bus_siz), 32'(2'(rem)));
      chk(bus_read == !wr, "R8 direction", 32'(bus_read), 32'(!wr));
      if (wr)
        for (int k = 0; k < n; k++)
          chk(bus_dout[8*(3-off-k) +: 8] == opb[cons+k], "R7 lane", 32'(bus_dout[8*(3-off-k) +: 8]), 32'(opb[cons+k]));
      w = int'($urandom % (maxwait + 1));
      for (int i = 0; i < w; i++) begin
        bus_ack = 2'b00;
        if (poke && i == 0) begin
          req_start = 1'b1; req_addr = 16'($urandom); req_size = 2'($urandom);
          req_write = !wr; req_fetch = 1'b1; req_wdata = $urandom;
        end
        @(negedge clk);
        req_start = 1'b0;
        chk(bus_cyc && bus_addr == cur, poke ? "R12 ignored start" : "R11 wait holds", 32'(bus_addr), 32'(cur));
        chk(bus_siz == 2'(rem) && !done, "R11 size held", 32'(bus_siz), 32'(2'(rem)));
      end
      fill = $urandom;
      for (int k = 0; k < n; k++) fill[8*(3-off-k) +: 8] = opb[cons+k];
      bus_din = fill;
      bus_ack = ack_of(port);
      @(negedge clk);
      bus_ack = 2'b00;
      cons += n;
      cur = cur + AW'(n);
    end
    chk(done == 1'b1 && bus_cyc == 1'b0, "R8 done pulse", {done, bus_cyc}, 32'b10);
    if (!wr) begin
      expr = '0;
      for (int i = 0; i < sz; i++) expr = {expr[23:0], opb[i]};
      chk(rdata == expr, "R8 read data", rdata, expr);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done one clock", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sizes[4];
    int ports[3];
    sizes = '{1, 2, 3, 4};
    ports = '{8, 16, 32};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!bus_cyc && !busy && !done && !addr_err, "R1 reset state", {bus_cyc, busy, done, addr_err}, 32'd0);

    // R13 directed: four-byte write at offset 1, 16-bit port
    @(negedge clk);
    req_start = 1'b1; req_addr = 16'h0101; req_size = 2'b00; req_write = 1'b1;
    req_fetch = 1'b0; req_wdata = 32'hA1B2C3D4;
    @(negedge clk);
    req_start = 1'b0;
    chk(bus_addr[2:0] == 3'b001 && bus_siz == 2'b00, "R13 cycle 1", {bus_addr[2:0], bus_siz}, 32'b00100);
    chk(bus_dout[31:24] == 8'hA1, "R13 cycle 1 data", 32'(bus_dout[31:24]), 32'hA1);
    bus_ack = 2'b10; @(negedge clk);
    chk(bus_addr[2:0] == 3'b010 && bus_siz == 2'b11, "R13 cycle 2", {bus_addr[2:0], bus_siz}, 32'b01011);
    chk(bus_dout[31:16] == 16'hB2C3, "R13 cycle 2 data", 32'(bus_dout[31:16]), 32'hB2C3);
    @(negedge clk);
    chk(bus_addr[2:0] == 3'b100 && bus_siz == 2'b01, "R13 cycle 3", {bus_addr[2:0], bus_siz}, 32'b10001);
    chk(bus_dout[31:24] == 8'hD4, "R13 cycle 3 data", 32'(bus_dout[31:24]), 32'hD4);
    @(negedge clk);
    bus_ack = 2'b00;
    chk(done && !bus_cyc, "R13 complete", {done, bus_cyc}, 32'b10);
    @(negedge clk);

    // directed corners: odd fetch, even fetch, address wrap, every alignment/port
    run_op(16'h0201, 2, 1'b0, 1'b1, 32, 0, 1'b0);
    run_op(16'h0202, 2, 1'b0, 1'b1, 32, 0, 1'b0);
    run_op(16'hFFFE, 4, 1'b0, 1'b0, 16, 1, 1'b0);
    run_op(16'hFFFF, 4, 1'b1, 1'b0, 32, 0, 1'b0);
    foreach (ports[p])
      for (int off = 0; off < 4; off++)
        foreach (sizes[s]) begin
          run_op(16'h1000 + 16'(off), sizes[s], 1'b1, 1'b0, ports[p], 0, 1'b0);
          run_op(16'h2000 + 16'(off), sizes[s], 1'b0, 1'b0, ports[p], 0, 1'b0);
        end

    // constrained random
    for (int i = 0; i < 400; i++)
      run_op(16'($urandom), sizes[$urandom % 4], 1'($urandom), ($urandom % 8) == 0,
             ports[$urandom % 3], 3, ($urandom % 4) == 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule